// File: doc/BRIEF.md
# Three-Round SPN Payload Decoder

This block turns an encoded 64-bit payload word back into the word that was written into the packet buffer. The matching encoder XORs the word with a first round key, runs it through a 4-bit substitution layer and a fixed bit permutation, repeats that with a second key, and finishes with an XOR of a third key. The decoder undoes those steps in reverse. It first XORs the word with the third key. It then runs two inverse rounds, each made of the inverse permutation, the inverse substitution layer, and an XOR with the second key and then the first key. A per-word bypass tag marks words that were never encoded; those words leave unchanged.

The only key the decoder receives is the 80-bit key stored alongside the frame. It therefore rebuilds the three round keys itself, using the same forward key schedule as the encoder, during a key-load phase before the data rounds. A word is taken through a valid/ready handshake. While that word is being decoded, the block accepts nothing new. The result is held with a valid flag until the consumer takes it.

Control is a seven-state machine:
- `ST_IDLE`: ready for input. It moves to `ST_KEY1` on an accepted word, or to `ST_HOLD` when the bypass tag is set.
- `ST_KEY1`: first key update, always followed by `ST_KEY2`.
- `ST_KEY2`: second key update, always followed by `ST_WHITEN`.
- `ST_WHITEN`: XOR with the third round key, always followed by `ST_RND_B`.
- `ST_RND_B`: inverse round using the second key, always followed by `ST_RND_A`.
- `ST_RND_A`: inverse round using the first key, always followed by `ST_HOLD`.
- `ST_HOLD`: output valid. It returns to `ST_IDLE` when the consumer takes the word.

Top module: `payload_unscrambler`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only while no word is in flight. A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1.
- R3: The round keys come from the stored key. The first is key bits [79:16]. Each later key is bits [79:16] after one schedule update of the previous key register. An update rotates the register left by 61, passes bits [79:76] through the forward S-box, and XORs bits [19:15] with the update counter, which is 1 and then 2.
- R4: The inverse S-box maps nibble values 0..F to 5,E,F,8,C,1,2,D,B,4,6,3,0,7,9,A. The forward S-box maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Nibble n of the word is bits [4n+3:4n].
- R5: The inverse permutation sets output bit i to input bit (16·i) mod 63 for i from 0 to 62. Bit 63 maps to itself.
- R6: For a non-bypassed word, the output is the input XORed with the third key, then run through two inverse rounds. Each inverse round is: inverse permutation, inverse S-box layer, then XOR with a key. The first inverse round uses the second key and the second uses the first key. The result equals the original plaintext.
- R7: When the bypass tag is 1 on acceptance, the output equals the input word unchanged, and `out_valid` rises one cycle after acceptance.
- R8: For a non-bypassed word, `out_valid` rises six clock edges after the accepting edge, counting the accepting edge as the first.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_word` stays unchanged.
- R10: On the edge where `out_valid` and `out_ready` are both 1, the word leaves, and `in_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Encoded word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 64 | Encoded payload word |
| in_key | input | 80 | Key stored with the frame |
| in_bypass | input | 1 | Word was not encoded; pass it through |
| out_valid | output | 1 | Restored word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 64 | Restored payload word |

## Verification
The bench runs plaintexts through its own encoder and requires an exact round trip.

Each kind of mistake has its own test:
- **All-zero key with every nibble value present.** A wrong inverse S-box entry shows up as a bad nibble here.
- **Single-bit plaintexts.** An inverse permutation built as the forward one moves the bit to the wrong place.
- **Random keys.** A swapped round-key order, a wrong rotate amount or a missing counter XOR corrupts almost every word.
- **Bypass words.** A pass-through that still decodes, or that takes the long path, fails both the data check and the per-cycle valid check.
- **Long `out_ready` stalls.** A design that drops or changes the held word fails the per-cycle valid and data checks.

// File: rtl/spn_dec_pkg.sv
package spn_dec_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_WHITEN,
        ST_RND_B,
        ST_RND_A,
        ST_HOLD
    } dec_state_e;

    function automatic logic [NIB_W-1:0] sbox_fwd(input logic [NIB_W-1:0] x);
        logic [NIB_W-1:0] y;
        unique case (x)
            4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
            4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
            4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
            4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
        endcase
        return y;
    endfunction

    function automatic logic [NIB_W-1:0] sbox_inv(input logic [NIB_W-1:0] x);
        logic [NIB_W-1:0] y;
        unique case (x)
            4'h0: y = 4'h5;  4'h1: y = 4'hE;  4'h2: y = 4'hF;  4'h3: y = 4'h8;
            4'h4: y = 4'hC;  4'h5: y = 4'h1;  4'h6: y = 4'h2;  4'h7: y = 4'hD;
            4'h8: y = 4'hB;  4'h9: y = 4'h4;  4'hA: y = 4'h6;  4'hB: y = 4'h3;
            4'hC: y = 4'h0;  4'hD: y = 4'h7;  4'hE: y = 4'h9;  default: y = 4'hA;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/spn_dec_keystep.sv
module spn_dec_keystep
    import spn_dec_pkg::*;
#(
    parameter int KEY_W  = 80,
    parameter int ROT    = 61,
    parameter int CNT_LO = 15,
    parameter int CNT_W  = 5
) (
    input  logic [KEY_W-1:0] key_in,
    input  logic [CNT_W-1:0] upd_cnt,
    output logic [KEY_W-1:0] key_out
);
    logic [KEY_W-1:0] rotated;

    // rotate left by ROT
    assign rotated = {key_in[KEY_W-ROT-1:0], key_in[KEY_W-1:KEY_W-ROT]};

    always_comb begin
        key_out = rotated;
        key_out[KEY_W-1 -: NIB_W] = sbox_fwd(rotated[KEY_W-1 -: NIB_W]);
        key_out[CNT_LO+CNT_W-1:CNT_LO] = rotated[CNT_LO+CNT_W-1:CNT_LO] ^ upd_cnt;
    end
endmodule

// File: rtl/spn_dec_invlayer.sv
module spn_dec_invlayer
    import spn_dec_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int N_NIB  = WORD_W / NIB_W;
    localparam int STRIDE = WORD_W / NIB_W;

    logic [WORD_W-1:0] permuted;

    generate
        for (genvar i = 0; i < WORD_W - 1; i++) begin : g_perm
            assign permuted[i] = din[(i * STRIDE) % (WORD_W - 1)];
        end
        assign permuted[WORD_W-1] = din[WORD_W-1];

        for (genvar n = 0; n < N_NIB; n++) begin : g_sbox
            assign dout[n*NIB_W +: NIB_W] = sbox_inv(permuted[n*NIB_W +: NIB_W]);
        end
    endgenerate
endmodule

// File: rtl/spn_dec_fsm.sv
module spn_dec_fsm
    import spn_dec_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bypass,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load,
    output logic             key_step,
    output logic             key_second,
    output logic [CNT_W-1:0] upd_cnt,
    output logic             whiten,
    output logic             round_en,
    output logic             round_last
);
    dec_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = in_bypass ? ST_HOLD : ST_KEY1;
            ST_KEY1:   state_nx = ST_KEY2;
            ST_KEY2:   state_nx = ST_WHITEN;
            ST_WHITEN: state_nx = ST_RND_B;
            ST_RND_B:  state_nx = ST_RND_A;
            ST_RND_A:  state_nx = ST_HOLD;
            ST_HOLD:   if (out_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        load       = 1'b0;
        key_step   = 1'b0;
        key_second = 1'b0;
        upd_cnt    = '0;
        whiten     = 1'b0;
        round_en   = 1'b0;
        round_last = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
            end
            ST_KEY1: begin
                key_step = 1'b1;
                upd_cnt  = CNT_W'(1);
            end
            ST_KEY2: begin
                key_step   = 1'b1;
                key_second = 1'b1;
                upd_cnt    = CNT_W'(2);
            end
            ST_WHITEN: whiten = 1'b1;
            ST_RND_B:  round_en = 1'b1;
            ST_RND_A: begin
                round_en   = 1'b1;
                round_last = 1'b1;
            end
            ST_HOLD:   out_valid = 1'b1;
            default: ;
        endcase
    end

    AST_KEY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_KEY1 |=> state == ST_KEY2); // R3

    AST_ROUND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WHITEN |=> state == ST_RND_B); // R6
endmodule

// File: rtl/payload_unscrambler.sv
module payload_unscrambler
    import spn_dec_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int KEY_W  = 80,
    parameter int ROT    = 61,
    parameter int CNT_LO = 15,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [KEY_W-1:0]  in_key,
    input  logic              in_bypass,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    localparam int RK_LO = KEY_W - WORD_W;

    logic             load, key_step, key_second, whiten, round_en, round_last;
    logic [CNT_W-1:0] upd_cnt;

    logic [KEY_W-1:0]  key_r, key_nx;
    logic [WORD_W-1:0] data_r, layer_out;
    logic [WORD_W-1:0] rk1_r, rk2_r, rk3_r;

    spn_dec_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_bypass  (in_bypass),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .load       (load),
        .key_step   (key_step),
        .key_second (key_second),
        .upd_cnt    (upd_cnt),
        .whiten     (whiten),
        .round_en   (round_en),
        .round_last (round_last)
    );

    spn_dec_keystep #(.KEY_W(KEY_W), .ROT(ROT), .CNT_LO(CNT_LO), .CNT_W(CNT_W)) u_keystep (
        .key_in  (key_r),
        .upd_cnt (upd_cnt),
        .key_out (key_nx)
    );

    spn_dec_invlayer #(.WORD_W(WORD_W)) u_invlayer (
        .din  (data_r),
        .dout (layer_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_r  <= '0;
            data_r <= '0;
            rk1_r  <= '0;
            rk2_r  <= '0;
            rk3_r  <= '0;
        end else begin
            if (load) begin
                key_r  <= in_key;
                data_r <= in_word;
                rk1_r  <= in_key[KEY_W-1:RK_LO];
            end
            if (key_step) begin
                key_r <= key_nx;
                if (key_second) rk3_r <= key_nx[KEY_W-1:RK_LO];
                else            rk2_r <= key_nx[KEY_W-1:RK_LO];
            end
            if (whiten)
                data_r <= data_r ^ rk3_r;
            if (round_en)
                data_r <= layer_out ^ (round_last ? rk1_r : rk2_r);
        end
    end

    assign out_word = data_r;

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> in_ready && !out_valid); // R1

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R2

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_bypass) |=> out_valid && out_word == $past(in_word)); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_word)); // R9

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> in_ready); // R10
endmodule

// File: tb/payload_unscrambler_bench.sv
module payload_unscrambler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_word = '0;
    logic [79:0] in_key = '0;
    logic        in_bypass = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_word;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // reference model state
    logic [63:0] exp_q[$];
    string       tag_q[$];
    bit          m_busy = 0;
    int          m_cd = 0;
    bit          m_on = 0;

    always #2.5 clk = ~clk;

    payload_unscrambler u_payload_unscrambler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_key(in_key), .in_bypass(in_bypass),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    function automatic logic [3:0] fs(input logic [3:0] x);
        logic [3:0] t[16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                              4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
        return t[x];
    endfunction

    function automatic logic [79:0] kupd(input logic [79:0] k, input int c);
        logic [79:0] r;
        r = {k[18:0], k[79:19]};
        r[79:76] = fs(r[79:76]);
        r[19:15] = r[19:15] ^ 5'(c);
        return r;
    endfunction

    function automatic logic [63:0] slayer(input logic [63:0] s);
        logic [63:0] o;
        for (int n = 0; n < 16; n++) o[n*4 +: 4] = fs(s[n*4 +: 4]);
        return o;
    endfunction

    function automatic logic [63:0] player(input logic [63:0] s);
        logic [63:0] o;
        for (int i = 0; i < 63; i++) o[(i * 16) % 63] = s[i];
        o[63] = s[63];
        return o;
    endfunction

    function automatic logic [63:0] encode(input logic [63:0] pt, input logic [79:0] key);
        logic [79:0] k;
        logic [63:0] s;
        k = key;
        s = pt ^ k[79:16];
        s = player(slayer(s));
        k = kupd(k, 1);
        s = s ^ k[79:16];
        s = player(slayer(s));
        k = kupd(k, 2);
        s = s ^ k[79:16];
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle-by-cycle reference model and comparison
    always @(negedge clk) begin
        cycles++;
        if (m_on) begin
            check(in_ready == !m_busy, "R2/R10 in_ready", 64'(in_ready), 64'(!m_busy));
            check(out_valid == (m_busy && m_cd == 0), "R8/R9 out_valid",
                  64'(out_valid), 64'(m_busy && m_cd == 0));
            if (out_valid && m_busy && m_cd == 0)
                check(out_word == exp_q[0], tag_q[0], out_word, exp_q[0]);
            if (!m_busy && in_valid) begin
                m_busy = 1;
                m_cd   = in_bypass ? 0 : 5;
            end else if (m_busy && m_cd > 0) begin
                m_cd--;
            end else if (m_busy && out_ready) begin
                m_busy = 0;
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic send(input logic [63:0] pt, input logic [79:0] key, input bit byp, input string tag);
        exp_q.push_back(pt);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        while (!in_ready) begin @(posedge clk); #1; end
        in_word   = byp ? pt : encode(pt, key);
        in_key    = key;
        in_bypass = byp;
        in_valid  = 1'b1;
        @(posedge clk); #1;
        in_valid  = 1'b0;
        in_word   = '1;
        in_key    = '1;
        while (m_busy || exp_q.size() != 0) begin @(posedge clk); #1; end
    endtask

    initial begin
        logic [63:0] w;
        logic [79:0] k;
        repeat (3) @(posedge clk);
        #1;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state",
              {62'd0, in_ready, out_valid}, 64'd2);
        rst_n = 1'b1;
        @(posedge clk); #1;
        m_on = 1;

        // R4: zero key, every nibble value
        send(64'h0123_4567_89AB_CDEF, 80'd0, 0, "R4 nibble map");
        send(64'hFEDC_BA98_7654_3210, 80'd0, 0, "R4 nibble map");
        // R5: single-bit plaintexts
        for (int b = 0; b < 64; b += 7)
            send(64'd1 << b, 80'h0, 0, "R5 permutation");
        send(64'd1 << 63, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 0, "R5 permutation");
        // R3: random keys
        for (int i = 0; i < 40; i++) begin
            k = {$urandom, $urandom, 16'($urandom)};
            send(64'hDEAD_BEEF_0BAD_F00D, k, 0, "R3 key schedule");
        end
        // R6: random words and keys
        for (int i = 0; i < 60; i++) begin
            w = {$urandom, $urandom};
            k = {$urandom, $urandom, 16'($urandom)};
            send(w, k, 0, "R6 round trip");
        end
        // R7: bypass
        for (int i = 0; i < 8; i++) begin
            w = {$urandom, $urandom};
            send(w, 80'h1234_5678_9ABC_DEF0_1357, 1, "R7 bypass");
        end
        // R9: stalled consumer, decode and bypass
        fork
            begin
                out_ready = 1'b0;
                repeat (20) @(posedge clk);
                #1 out_ready = 1'b1;
            end
            send(64'hCAFE_0000_1111_2222, 80'h5555_AAAA_5555_AAAA_5555, 0, "R9 hold word");
        join
        fork
            begin
                out_ready = 1'b0;
                repeat (9) @(posedge clk);
                #1 out_ready = 1'b1;
            end
            send(64'h0F0F_0F0F_F0F0_F0F0, 80'd7, 1, "R9 hold bypass");
        join
        repeat (4) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<50000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule